// File: doc/BRIEF.md
# Word-Addressed Lookup Table Bus Slave

This block puts a small lookup table behind a parallel bus that uses a fully interlocked four-phase handshake. The master shares the slave's clock and changes its outputs on the falling edge. It drives a 20-bit byte address, a 16-bit write data word, an enable strobe and a write/read select. The slave answers with an active-low acknowledge. The slave holds the acknowledge low until it sees the enable drop. Only then does it release the acknowledge, and only then may the master start its next access.

The table holds `LUT_BYTES/2` entries of `ENTRY_W` bits each. Each entry occupies one 16-bit bus word inside a window that starts at `BASE_ADDR`, so consecutive entries lie two byte addresses apart and address bit 0 plays no part. A write stores the low `ENTRY_W` bits of the data word. A read returns the entry zero-extended to the bus width. The read data is driven, with its output enable raised, only while a read is being acknowledged. The slave ignores accesses outside the window completely.

Top module: `lut_bus_slave`

## Requirements
- R1: While `rst_n` is low and after it is released, `bus_ack_n` is 1, `bus_rdata_oe` is 0 and `bus_rdata` is 0 until an access is captured.
- R2: When `bus_ack_n` is 1 and a rising edge samples `bus_en`=1 with an address inside [BASE_ADDR, BASE_ADDR+LUT_BYTES), `bus_ack_n` is 0 after that same edge.
- R3: `bus_ack_n` stays 0 for every rising edge that samples `bus_en`=1. It returns to 1 after the first rising edge that samples `bus_en`=0.
- R4: On a captured access with `bus_wr`=1, entry (addr-BASE_ADDR)>>1 takes `bus_wdata[ENTRY_W-1:0]`. The upper data bits are ignored, and addr bit 0 does not select a different entry.
- R5: On a captured access with `bus_wr`=0, `bus_rdata[ENTRY_W-1:0]` carries the addressed entry and `bus_rdata[15:ENTRY_W]` is 0.
- R6: `bus_rdata_oe` is 1 only while a read is acknowledged, meaning `bus_ack_n`=0 for a capture with `bus_wr`=0. Whenever `bus_rdata_oe` is 0, `bus_rdata` is 0.
- R7: An enabled access outside the window gives no acknowledge and changes no table entry.
- R8: Exactly one write is performed per handshake. Changes to `bus_wdata` while the acknowledge is held low are not stored, and the read data stays stable while the acknowledge is held.
- R9: Reset, including a reset in the middle of a handshake, returns the slave to idle with `bus_ack_n`=1 and leaves the table contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 20 | Byte address from the master |
| bus_wdata | input | 16 | Write data from the master |
| bus_en | input | 1 | Access strobe, active high |
| bus_wr | input | 1 | 1 selects write, 0 selects read |
| bus_ack_n | output | 1 | Active-low acknowledge |
| bus_rdata | output | 16 | Read data, zero-extended table entry |
| bus_rdata_oe | output | 1 | Read data output enable, high while a read is acknowledged |

## Verification
The acknowledge, the read data and its output enable all become valid after the rising edge that captures the enable. The bench drives each access on a falling edge and checks them on the very next falling edge. The release of the acknowledge is checked on the falling edge after the edge that samples the enable low. A write is observed through a read access issued later. Out-of-window strobes are held for several edges, with the acknowledge checked high on each. A complete read-back of the table then confirms that nothing changed.

// File: rtl/lut_slv_pkg.sv
package lut_slv_pkg;

  // Handshake phases: idle waits for a strobe, held waits for the strobe to drop
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HELD = 1'b1
  } hs_state_e;

  // Decoded view of one captured access
  typedef struct packed {
    logic cap;   // access accepted this edge
    logic wr;    // accepted access is a write
  } hs_cmd_t;

endpackage

// File: rtl/lut_addr_decode.sv
module lut_addr_decode #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BASE_ADDR = 32'h0000_0100,
  parameter int unsigned LUT_BYTES = 64,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W:0]   WIN_LO = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0]   WIN_HI = (ADDR_W+1)'(BASE_ADDR + LUT_BYTES);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic [ADDR_W:0]   addr_x;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    addr_x = {1'b0, addr};
    hit    = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    offset = addr - BASE_V;
    // word index: byte offset with the lane bit dropped
    idx    = IDX_W'(offset >> 1);
  end

endmodule

// File: rtl/lut_hs_fsm.sv
module lut_hs_fsm
  import lut_slv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    wr,
  input  logic    hit,
  output hs_cmd_t cmd,
  output logic    ack_n,
  output logic    rd_oe
);

  hs_state_e state_q, state_d;
  logic      rd_q, rd_d;
  logic      rd_ce;

  // next-state process
  always_comb begin
    state_d = state_q;
    cmd.cap = 1'b0;
    cmd.wr  = wr;
    unique case (state_q)
      HS_IDLE: begin
        if (en && hit) begin
          cmd.cap = 1'b1;
          state_d = HS_HELD;
        end
      end
      HS_HELD: begin
        if (!en) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
    rd_ce = cmd.cap;
    rd_d  = ~wr;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_ce) rd_q <= rd_d;
    end
  end

  assign ack_n = (state_q == HS_IDLE);
  assign rd_oe = (state_q == HS_HELD) && rd_q;

endmodule

// File: rtl/lut_store.sv
module lut_store #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ENTRY_W = 10,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] rd_entry_q;

  // upper bus bits are dropped on the way in
  assign wr_entry = ENTRY_W'(wdata);

  // table contents carry no reset
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_entry_q <= '0;
    else if (re) rd_entry_q <= mem[idx];
  end

  generate
    if (ENTRY_W < DATA_W) begin : g_pad
      assign rdata = {{(DATA_W-ENTRY_W){1'b0}}, rd_entry_q};
    end else begin : g_full
      assign rdata = rd_entry_q;
    end
  endgenerate

endmodule

// File: rtl/lut_bus_slave.sv
module lut_bus_slave
  import lut_slv_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ENTRY_W   = 10,
  parameter int unsigned LUT_BYTES = 64,
  parameter int unsigned BASE_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_en,
  input  logic              bus_wr,
  output logic              bus_ack_n,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe
);

  localparam int unsigned DEPTH = LUT_BYTES / 2;
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  hs_cmd_t          cmd;
  logic             rd_oe;
  logic [DATA_W-1:0] rd_word;
  logic             we, re;

  lut_addr_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .LUT_BYTES(LUT_BYTES),
    .IDX_W    (IDX_W)
  ) dec_i (
    .addr(bus_addr),
    .hit (hit),
    .idx (idx)
  );

  lut_hs_fsm fsm_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (bus_en),
    .wr   (bus_wr),
    .hit  (hit),
    .cmd  (cmd),
    .ack_n(bus_ack_n),
    .rd_oe(rd_oe)
  );

  assign we = cmd.cap && cmd.wr;
  assign re = cmd.cap && !cmd.wr;

  lut_store #(
    .DATA_W (DATA_W),
    .ENTRY_W(ENTRY_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) store_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (we),
    .re   (re),
    .idx  (idx),
    .wdata(bus_wdata),
    .rdata(rd_word)
  );

  assign bus_rdata_oe = rd_oe;
  assign bus_rdata    = rd_oe ? rd_word : '0;

endmodule

// File: rtl/lut_bus_slave_chk.sv
module lut_bus_slave_chk #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ENTRY_W   = 10,
  parameter int unsigned LUT_BYTES = 64,
  parameter int unsigned BASE_ADDR = 32'h0000_0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_en,
  input logic              bus_wr,
  input logic              bus_ack_n,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rdata_oe
);

  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE_ADDR + LUT_BYTES);

  logic in_win;
  assign in_win = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> bus_ack_n); // R1
  AST_ACK_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack_n && bus_en && in_win) |=> !bus_ack_n); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ack_n && bus_en) |=> !bus_ack_n); // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ack_n && !bus_en) |=> bus_ack_n); // R3
  AST_NO_ACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack_n && !(bus_en && in_win)) |=> bus_ack_n); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> ((bus_rdata >> ENTRY_W) == '0)); // R5
  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> !bus_ack_n); // R6
  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata_oe) |-> !$past(bus_wr)); // R6
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> (bus_rdata == '0)); // R6
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ack_n && bus_en) |=> $stable(bus_rdata)); // R8

endmodule

bind lut_bus_slave lut_bus_slave_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .ENTRY_W  (ENTRY_W),
  .LUT_BYTES(LUT_BYTES),
  .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_en      (bus_en),
  .bus_wr      (bus_wr),
  .bus_ack_n   (bus_ack_n),
  .bus_rdata   (bus_rdata),
  .bus_rdata_oe(bus_rdata_oe)
);

// File: tb/lut_bus_slave_tb_top.sv
`timescale 1ns/1ps
module lut_bus_slave_tb_top;

  localparam int unsigned BASE  = 32'h100;
  localparam int unsigned BYTES = 64;
  localparam int unsigned EW    = 10;
  localparam int unsigned DEPTH = BYTES / 2;
  localparam logic [15:0] EMASK = 16'((1 << EW) - 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_en, bus_wr;
  logic        bus_ack_n, bus_rdata_oe;
  logic [15:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  lut_bus_slave #(
    .ADDR_W(20), .DATA_W(16), .ENTRY_W(EW), .LUT_BYTES(BYTES), .BASE_ADDR(BASE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_ack_n(bus_ack_n),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int k);
    return 16'((i * 16'h09D3 + k * 16'h01F1) ^ 16'hA400);
  endfunction

  function automatic logic [19:0] waddr(input int i, input bit odd);
    return 20'(BASE + 2 * i) | 20'(odd);
  endfunction

  // all tasks start and end just after a falling edge
  task automatic bus_write(input logic [19:0] a, input logic [15:0] d, input int hold);
    chk("R3 idle before write", bus_ack_n, 1);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 ack after write capture", bus_ack_n, 0);
    chk("R6 no oe on write", bus_rdata_oe, 0);
    for (int h = 0; h < hold; h++) begin
      bus_wdata = ~d;   // R8: must not be stored
      @(posedge clk); @(negedge clk);
      chk("R3 ack held", bus_ack_n, 0);
    end
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = 'x; bus_addr = 'x;
    @(posedge clk); @(negedge clk);
    chk("R3 ack released", bus_ack_n, 1);
  endtask

  task automatic bus_read(input logic [19:0] a, input logic [15:0] exp, input int hold, input string req);
    chk("R6 oe low before read", bus_rdata_oe, 0);
    bus_addr = a; bus_wr = 1'b0; bus_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 ack after read capture", bus_ack_n, 0);
    chk("R6 oe during read", bus_rdata_oe, 1);
    chk(req, bus_rdata, exp);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 read data held", bus_rdata, exp);
    end
    bus_en = 1'b0; bus_addr = 'x;
    @(posedge clk); @(negedge clk);
    chk("R3 ack released after read", bus_ack_n, 1);
    chk("R6 oe dropped", bus_rdata_oe, 0);
    chk("R6 data zero when idle", bus_rdata, 0);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < DEPTH; i++) bus_read(waddr(i, i[0]), model[i], 0, req);
  endtask

  task automatic outside(input logic [19:0] a);
    bus_addr = a; bus_wdata = 16'hFFFF; bus_wr = 1'b1; bus_en = 1'b1;
    for (int h = 0; h < 3; h++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 no ack outside window", bus_ack_n, 1);
      chk("R7 no oe outside window", bus_rdata_oe, 0);
    end
    bus_en = 1'b0; bus_wr = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ack high in reset", bus_ack_n, 1);
    chk("R1 oe low in reset", bus_rdata_oe, 0);
    chk("R1 rdata zero in reset", bus_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack high after reset", bus_ack_n, 1);

    // pass 1: even addresses, no hold
    for (int i = 0; i < DEPTH; i++) begin
      bus_write(waddr(i, 1'b0), pat(i, 1), 0);
      model[i] = pat(i, 1) & EMASK;
    end
    read_all("R4 R5 read back pass 1");

    // pass 2: odd addresses, varying hold, data changed during hold
    for (int i = 0; i < DEPTH; i++) begin
      bus_write(waddr(i, 1'b1), pat(i, 7), i % 3);
      model[i] = pat(i, 7) & EMASK;
    end
    for (int i = 0; i < DEPTH; i++) bus_read(waddr(i, ~i[0]), model[i], i % 2, "R4 R8 read back pass 2");

    // out-of-window accesses
    outside(20'(BASE - 2));
    outside(20'(BASE - 1));
    outside(20'(BASE + BYTES));
    outside(20'(BASE + BYTES + 1));
    outside(20'hFFFFF);
    read_all("R7 table unchanged");

    // reset in the middle of a held write
    bus_addr = waddr(5, 1'b0); bus_wdata = 16'h0155; bus_wr = 1'b1; bus_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 ack before mid reset", bus_ack_n, 0);
    model[5] = 16'h0155 & EMASK;
    rst_n = 1'b0;
    #1;
    chk("R9 ack released by reset", bus_ack_n, 1);
    bus_en = 1'b0; bus_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 idle after reset", bus_ack_n, 1);
    read_all("R9 table kept across reset");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule